// File: doc/BRIEF.md
# PCM Frame-Synchronous Voice Serial Port

This block is a full-duplex serial port for voice samples. In each frame it shifts one transmit sample out on `pcm_o` and one receive sample in from `pcm_i`. The only clock is the external bit clock. A frame sync input marks where the most significant bit of each word sits. The port carries two word formats: 8-bit companded words and 14-bit two's-complement linear words. Both go MSB first. The sync can follow long-frame timing, where the MSB starts together with the sync rise, or short-frame timing, where a one-bit-wide sync pulse comes one bit before the MSB.

On the parallel side, the block takes a transmit sample. It returns each completed receive sample together with a one-cycle valid strobe. Separate enables for transmit and receive let software mute either direction. A power-down input parks the serial output high and stops all word traffic. The sign of the last accepted receive word is available on its own output, so it can drive a general-purpose pin directly.

Transmit bits change on the rising clock edge. Receive bits are captured on the falling edge, in the middle of the bit, and enter the shift register at the next rising edge. Word format and both enables are sampled when a word starts. The sync timing select is a static configuration input.

Top module: `pcm_frame_port`

## Requirements
- R1: While reset is asserted and after it is released, `pcm_o` is 0, `rx_valid_o` is 0, `rx_sample_o` is 0 and `rx_sign_o` is 0.
- R2: With `short_frame_i`=0, a word starts at the rising edge that first samples `sync_i` high after it was low. The MSB appears on `pcm_o` from that edge. Each following edge presents the next lower bit.
- R3: With `short_frame_i`=1, a word starts one rising edge after the edge that sampled the sync pulse high. The MSB appears from that later edge.
- R4: With `lin_mode_i`=1 at word start, the port sends and receives 14 bits and uses `tx_sample_i[13:0]`. With `lin_mode_i`=0, it sends 8 bits from `tx_sample_i[7:0]` and ignores bits 13:8. A companded receive word appears on `rx_sample_o[7:0]` with bits 13:8 at 0.
- R5: `pcm_o` is 0 in every bit time that is not part of a word being sent.
- R6: While `pd_i`=1, `pcm_o` is 1 and `rx_valid_o` stays 0. Word counting is cleared.
- R7: If `tx_en_i`=0 at word start, `pcm_o` stays 0 for the whole word.
- R8: The receive bit for each bit time is sampled on the falling clock edge. When the last bit of a word has been shifted in, `rx_sample_o` shows the word and `rx_valid_o` is 1 for exactly one cycle.
- R9: If `rx_en_i`=0 at word start, the received word is discarded. No valid strobe is raised, and `rx_sample_o` and `rx_sign_o` keep their previous values.
- R10: `rx_sign_o` equals the MSB of the last accepted receive word: bit 13 in linear mode, bit 7 in companded mode. It holds until the next accepted word.
- R11: A new sync start in the middle of a word restarts both directions. The partial receive word is dropped without a valid strobe, and the transmit word is sent again from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down: output high, no word traffic |
| short_frame_i | input | 1 | 1 = short-frame sync, 0 = long-frame sync |
| lin_mode_i | input | 1 | 1 = 14-bit linear word, 0 = 8-bit companded word |
| sync_i | input | 1 | Frame sync |
| tx_en_i | input | 1 | Transmit enable, sampled at word start |
| tx_sample_i | input | 14 | Transmit sample, sampled at word start |
| rx_en_i | input | 1 | Receive enable, sampled at word start |
| pcm_i | input | 1 | Serial receive data |
| pcm_o | output | 1 | Serial transmit data |
| rx_sample_o | output | 14 | Last accepted receive sample |
| rx_valid_o | output | 1 | One-cycle strobe for a new receive sample |
| rx_sign_o | output | 1 | Sign of the last accepted receive sample |

## Verification
The bench builds the port with its default word widths of 14 and 8 bits. It sweeps every combination of word format, sync timing, transmit enable and receive enable. Each combination runs with several computed sample values, and receive data comes either looped back from `pcm_o` or from an independent bench pattern. Every bit time of every frame is compared against a bit position the bench computes itself. This covers the one-bit offset between the two sync timings, the idle-low bits after each word, and a sync restart in the middle of a 14-bit word. Power-down frames are placed between normal frames, so the bench also sees that the receive result and sign hold across them.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    SYNC_LONG  = 1'b0,
    SYNC_SHORT = 1'b1
  } sync_mode_e;

  function automatic int unsigned word_len(input logic lin, input int unsigned lin_w,
                                           input int unsigned cmp_w);
    return lin ? lin_w : cmp_w;
  endfunction
endpackage

// File: rtl/pcm_frame_sync.sv
module pcm_frame_sync
  import pcm_port_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic short_frame_i,
  input  logic sync_i,
  output logic start_o
);
  logic sync_q, sync_q2;
  logic rise_now, rise_late;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q  <= sync_i;
      sync_q2 <= sync_q;
    end
  end

  assign rise_now  = sync_i & ~sync_q;
  assign rise_late = sync_q & ~sync_q2;

  always_comb begin
    unique case (sync_mode_e'(short_frame_i))
      SYNC_SHORT: start_o = rise_late & ~pd_i;
      default:    start_o = rise_now & ~pd_i;
    endcase
  end

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !short_frame_i) |=> !start_o);  // R2
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int unsigned LIN_W = 14,
  parameter int unsigned CMP_W = 8,
  parameter int unsigned CNT_W = $clog2(LIN_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             start_i,
  input  logic             lin_i,
  input  logic             tx_en_i,
  input  logic [LIN_W-1:0] tx_word_i,
  output logic             bit_o
);
  import pcm_port_pkg::*;

  localparam logic [CNT_W-1:0] LEFT_LIN = CNT_W'(LIN_W - 1);
  localparam logic [CNT_W-1:0] LEFT_CMP = CNT_W'(CMP_W - 1);

  logic [LIN_W-1:0] sh_q, aligned;
  logic [CNT_W-1:0] left_q;
  logic             en_q;

  // companded word is MSB-aligned so one shift path serves both formats
  assign aligned = lin_i ? tx_word_i
                         : {tx_word_i[CMP_W-1:0], {(LIN_W - CMP_W){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      en_q   <= 1'b0;
      bit_o  <= 1'b0;
    end else if (pd_i) begin
      left_q <= '0;
      en_q   <= 1'b0;
      bit_o  <= 1'b0;
    end else if (start_i) begin
      en_q   <= tx_en_i;
      bit_o  <= tx_en_i & aligned[LIN_W-1];
      sh_q   <= aligned << 1;
      left_q <= lin_i ? LEFT_LIN : LEFT_CMP;
    end else if (left_q != '0) begin
      bit_o  <= en_q & sh_q[LIN_W-1];
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
    end else begin
      bit_o  <= 1'b0;
    end
  end

  AST_TX_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> $past(start_i || left_q != '0));  // R5
  AST_TX_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !bit_o);  // R7
  AST_TX_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q < CNT_W'(LIN_W));  // R4
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int unsigned LIN_W = 14,
  parameter int unsigned CMP_W = 8,
  parameter int unsigned CNT_W = $clog2(LIN_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             start_i,
  input  logic             lin_i,
  input  logic             rx_en_i,
  input  logic             pcm_i,
  output logic [LIN_W-1:0] data_o,
  output logic             valid_o,
  output logic             sign_o
);
  localparam logic [CNT_W-1:0] LEN_LIN = CNT_W'(LIN_W);
  localparam logic [CNT_W-1:0] LEN_CMP = CNT_W'(CMP_W);

  logic             smp_q;
  logic [LIN_W-1:0] sh_q, nxt;
  logic [CNT_W-1:0] left_q;
  logic             en_q, lin_q;

  // mid-bit capture on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 1'b0;
    else         smp_q <= pcm_i;
  end

  assign nxt = {sh_q[LIN_W-2:0], smp_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      en_q    <= 1'b0;
      lin_q   <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
    end else if (pd_i) begin
      left_q  <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      sh_q    <= '0;
      left_q  <= lin_i ? LEN_LIN : LEN_CMP;
      en_q    <= rx_en_i;
      lin_q   <= lin_i;
      valid_o <= 1'b0;
    end else if (left_q != '0) begin
      sh_q    <= nxt;
      left_q  <= left_q - 1'b1;
      valid_o <= 1'b0;
      if (left_q == CNT_W'(1) && en_q) begin
        valid_o <= 1'b1;
        data_o  <= lin_q ? nxt : LIN_W'(nxt[CMP_W-1:0]);
        sign_o  <= lin_q ? nxt[LIN_W-1] : nxt[CMP_W-1];
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R8
  AST_SIGN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sign_o == (lin_q ? data_o[LIN_W-1] : data_o[CMP_W-1]));  // R10
  AST_PD_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !valid_o);  // R6
  AST_RXOFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> ($stable(data_o) && $stable(sign_o)));  // R9
  AST_RX_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= CNT_W'(LIN_W));  // R11
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int unsigned LIN_W = 14,
  parameter int unsigned CMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             short_frame_i,
  input  logic             lin_mode_i,
  input  logic             sync_i,
  input  logic             tx_en_i,
  input  logic [LIN_W-1:0] tx_sample_i,
  input  logic             rx_en_i,
  input  logic             pcm_i,
  output logic             pcm_o,
  output logic [LIN_W-1:0] rx_sample_o,
  output logic             rx_valid_o,
  output logic             rx_sign_o
);
  localparam int unsigned CNT_W = $clog2(LIN_W + 1);

  logic start, tx_bit;

  pcm_frame_sync u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_i         (pd_i),
    .short_frame_i(short_frame_i),
    .sync_i       (sync_i),
    .start_o      (start)
  );

  pcm_tx_serializer #(.LIN_W(LIN_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_i     (pd_i),
    .start_i  (start),
    .lin_i    (lin_mode_i),
    .tx_en_i  (tx_en_i),
    .tx_word_i(tx_sample_i),
    .bit_o    (tx_bit)
  );

  pcm_rx_deserializer #(.LIN_W(LIN_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pd_i),
    .start_i(start),
    .lin_i  (lin_mode_i),
    .rx_en_i(rx_en_i),
    .pcm_i  (pcm_i),
    .data_o (rx_sample_o),
    .valid_o(rx_valid_o),
    .sign_o (rx_sign_o)
  );

  // parked high in power-down
  assign pcm_o = pd_i | tx_bit;

  AST_PD_TX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd_i) |-> !tx_bit);  // R6
endmodule

// File: tb/tb_pcm_frame_port.sv
module tb_pcm_frame_port;
  localparam int FRAME = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd = 1'b0, short_frame = 1'b0, lin = 1'b0, sync = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, loop = 1'b0, drv = 1'b0;
  logic [13:0] tx_sample = '0;
  logic pcm_in, pcm_out, rx_valid, rx_sign;
  logic [13:0] rx_sample;

  int checks = 0, errors = 0;
  logic [13:0] exp_data = '0;
  logic exp_sign = 1'b0;

  always #4 clk = ~clk;

  assign pcm_in = loop ? pcm_out : drv;

  pcm_frame_port dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_i(pd), .short_frame_i(short_frame),
    .lin_mode_i(lin), .sync_i(sync), .tx_en_i(tx_en), .tx_sample_i(tx_sample),
    .rx_en_i(rx_en), .pcm_i(pcm_in), .pcm_o(pcm_out), .rx_sample_o(rx_sample),
    .rx_valid_o(rx_valid), .rx_sign_o(rx_sign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int start_of(input int p, input int rs, input int off);
    return (rs != 0 && p >= rs + off) ? rs + off : off;
  endfunction

  // one frame; called just after a rising edge
  task automatic run_frame(input logic l, input logic sf, input logic te, input logic re,
                           input logic lp, input logic p_d, input logic [13:0] tw,
                           input logic [13:0] rw, input int rs);
    int n, off, st, idx;
    logic [13:0] twn, rwn, got;
    logic ebit, ev;
    n   = l ? 14 : 8;
    off = sf ? 1 : 0;
    twn = l ? tw : {6'b0, tw[7:0]};
    rwn = l ? rw : {6'b0, rw[7:0]};
    lin = l; short_frame = sf; tx_en = te; rx_en = re; loop = lp; pd = p_d;
    tx_sample = tw;
    for (int c = 0; c < FRAME; c++) begin
      if (sf) sync = (c == 0) || (rs != 0 && c == rs);
      else    sync = (c < 3) || (rs != 0 && c >= rs && c < rs + 3);
      begin
        int p, j;
        p = c - 1;
        st = start_of(p, rs, off);
        j = p - st;
        drv = (p >= 0 && j >= 0 && j < n) ? rwn[n-1-j] : 1'b0;
      end
      @(posedge clk); #1;
      st  = start_of(c, rs, off);
      idx = c - st;
      if (p_d) begin
        chk("R6 pcm high", pcm_out, 1);
        chk("R6 no valid", rx_valid, 0);
      end else begin
        ebit = (idx >= 0 && idx < n && te) ? twn[n-1-idx] : 1'b0;
        if (idx >= 0 && idx < n && te) chk(rs != 0 ? "R11 tx bit" : (sf ? "R3 tx bit" : "R2 tx bit"), pcm_out, ebit);
        else if (idx >= 0 && idx < n) chk("R7 tx off", pcm_out, 0);
        else chk("R5 idle low", pcm_out, 0);
        ev = re && (c == start_of(FRAME, rs, off) + n);
        chk(rs != 0 ? "R11 valid" : (re ? "R8 valid" : "R9 no valid"), rx_valid, ev);
        if (ev) begin
          got = lp ? (te ? twn : 14'h0) : rwn;
          exp_data = got;
          exp_sign = got[n-1];
          chk(l ? "R8 data" : "R4 data", rx_sample, exp_data);
        end
      end
    end
    chk(re ? "R8 held data" : "R9 held data", rx_sample, exp_data);
    chk("R10 sign", rx_sign, exp_sign);
    pd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pcm reset", pcm_out, 0);
    chk("R1 valid reset", rx_valid, 0);
    chk("R1 data reset", rx_sample, 0);
    chk("R1 sign reset", rx_sign, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pcm after reset", pcm_out, 0);
    for (int l = 0; l < 2; l++)
      for (int sf = 0; sf < 2; sf++)
        for (int te = 0; te < 2; te++)
          for (int re = 0; re < 2; re++)
            for (int k = 0; k < 6; k++) begin
              logic [13:0] tw, rw;
              tw = 14'((k * 16'h1A5B) ^ (l * 16'h03C1) ^ (sf * 16'h2E07) ^ (te * 16'h0155));
              rw = 14'((k * 16'h2C93) ^ (re * 16'h1F0A) ^ (l * 16'h0B6D) ^ 16'h2481);
              run_frame(l[0], sf[0], te[0], re[0], k[0], 1'b0, tw, rw, (k == 5) ? 5 : 0);
              if (k == 2) run_frame(l[0], sf[0], 1'b1, 1'b1, 1'b1, 1'b1, tw, rw, 0);
            end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule